// File: doc/BRIEF.md
# Shared Buffer FIFO Partitioner

This block splits one 16 KB buffer memory, addressed in 32-bit words, into four circular FIFOs: transmit status, transmit data (commands and payload words share it), receive status and receive data. A single size field in a configuration register sets how many kilobytes the transmit side owns. Each status FIFO gets a fixed 512-byte region. The transmit data FIFO gets the rest of the transmit allocation. The receive side gets every word the transmit side does not use. For each FIFO the block gives the base and last word of its region, the physical word addresses for the next write and the next read, and full and empty flags.

Each FIFO has a push strobe and a pop strobe. Back-pressure works like a valid/ready pair whose ready is the inverse of the flag. A push is accepted only while `full` is low, and a pop only while `empty` is low. A strobe raised against the flag is dropped and leaves no trace. Software may change the configuration only while both the transmitter and the receiver report idle. An accepted write sends every pointer back to its region base.

Top module: `shared_fifo_partitioner`

## Requirements
- R1: After reset the transmit size is 5 KB. All four FIFOs are empty and not full. Each FIFO's write and read addresses equal its region base, so the bases are 0, 128, 1280 and 1408.
- R2: A write with `cfg_we` high, both idle inputs high and bit 20 of the write data set is accepted. The new transmit size, in KB, is taken from write-data bits 19:16 and appears on `cfg_tx_kb` one cycle later.
- R3: An accepted size below 2 is stored as 2, and a size above 14 is stored as 14. `cfg_tx_kb` always lies between 2 and 14.
- R4: A write is ignored, and `cfg_tx_kb` keeps its value, when either idle input is low or when bit 20 of the write data is clear.
- R5: With a transmit size of K KB, FIFO 0 (transmit status) covers words 0 to 127. FIFO 1 (transmit data) covers 128 to K*256-1. FIFO 2 (receive status) covers K*256 to K*256+127. FIFO 3 (receive data) covers K*256+128 to 4095. `base` and `limit` report these inclusive bounds.
- R6: An accepted push advances that FIFO's `wr_addr` by one word, and an accepted pop advances its `rd_addr` by one word. Both addresses wrap from the region limit back to the region base and never leave the region.
- R7: A FIFO is full when it holds as many words as its region has. A push while full is ignored and leaves `wr_addr` unchanged.
- R8: A FIFO is empty when it holds no words. A pop while empty is ignored and leaves `rd_addr` unchanged.
- R9: A push and a pop on the same FIFO in the same cycle, neither against its flag, both take effect. The fill level stays the same.
- R10: An accepted configuration write returns all four FIFOs to empty, with both addresses at the new region bases. Any push or pop in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Write data: bit 20 enable key, bits 19:16 transmit size in KB |
| tx_idle | input | 1 | Transmitter is stopped |
| rx_idle | input | 1 | Receiver is stopped |
| push | input | 4 | Push strobes, index 0 tx status, 1 tx data, 2 rx status, 3 rx data |
| pop | input | 4 | Pop strobes, same indexing |
| full | output | 4 | Per-FIFO full flag (push not ready) |
| empty | output | 4 | Per-FIFO empty flag (pop not ready) |
| wr_addr | output | 4x12 | Physical word address for the next push |
| rd_addr | output | 4x12 | Physical word address for the next pop |
| base | output | 4x12 | First word of each region |
| limit | output | 4x12 | Last word of each region |
| cfg_tx_kb | output | 4 | Current transmit allocation in KB |

## Verification
The interesting collision is an accepted configuration write that arrives in the same cycle as push and pop strobes. The reset of the pointers must win, and the strobes must vanish without moving any pointer. The bench provokes this with a directed cycle that raises all four pushes and pops together with a valid write. It also drives occasional random writes, with random idle inputs and key bit, during random traffic. After each such cycle it expects every FIFO to be empty with both addresses at the new bases. A second overlap, a push and a pop on the same FIFO, is judged by checking that both addresses move while the flags stay unchanged.

// File: rtl/fpart_pkg.sv
package fpart_pkg;
  localparam int REG_W      = 32;
  localparam int SIZE_LSB   = 16;
  localparam int KBW        = 4;
  localparam int KEY_BIT    = 20;
  localparam int WORD_BYTES = 4;
  localparam int MEM_KB     = 16;
  localparam int KB_WORDS   = 1024 / WORD_BYTES;
  localparam int MEM_WORDS  = MEM_KB * KB_WORDS;
  localparam int AW         = $clog2(MEM_WORDS);
  localparam int CW         = AW + 1;
  localparam int STAT_WORDS = 512 / WORD_BYTES;
  localparam int NFIFO      = 4;
  localparam int MIN_KB     = 2;
  localparam int MAX_KB     = 14;
  localparam int RST_KB     = 5;

  typedef enum logic [1:0] {Q_TXS, Q_TXD, Q_RXS, Q_RXD} fifo_id_e;
endpackage

// File: rtl/fpart_cfg_reg.sv
module fpart_cfg_reg
  import fpart_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic           key,
  input  logic [KBW-1:0] size_in,
  input  logic           tx_idle,
  input  logic           rx_idle,
  output logic [KBW-1:0] tx_kb,
  output logic           accept
);
  function automatic logic [KBW-1:0] clamp_kb(input logic [KBW-1:0] v);
    if (v < KBW'(MIN_KB)) return KBW'(MIN_KB);
    if (v > KBW'(MAX_KB)) return KBW'(MAX_KB);
    return v;
  endfunction

  // only a keyed write with both engines stopped may change the split
  assign accept = we & key & tx_idle & rx_idle;

  always_ff @(posedge clk) begin
    if (!rst_n)      tx_kb <= KBW'(RST_KB);
    else if (accept) tx_kb <= clamp_kb(size_in);
  end
endmodule

// File: rtl/fpart_region_map.sv
module fpart_region_map
  import fpart_pkg::*;
(
  input  logic [KBW-1:0]            tx_kb,
  output logic [NFIFO-1:0][AW-1:0]  base,
  output logic [NFIFO-1:0][AW-1:0]  limit,
  output logic [NFIFO-1:0][CW-1:0]  depth
);
  logic [CW-1:0] tx_words;

  always_comb begin
    tx_words     = CW'(tx_kb) * CW'(KB_WORDS);
    base[Q_TXS]  = '0;
    depth[Q_TXS] = CW'(STAT_WORDS);
    base[Q_TXD]  = AW'(STAT_WORDS);
    depth[Q_TXD] = tx_words - CW'(STAT_WORDS);
    base[Q_RXS]  = tx_words[AW-1:0];
    depth[Q_RXS] = CW'(STAT_WORDS);
    base[Q_RXD]  = tx_words[AW-1:0] + AW'(STAT_WORDS);
    depth[Q_RXD] = CW'(MEM_WORDS) - tx_words - CW'(STAT_WORDS);
  end

  for (genvar g = 0; g < NFIFO; g++) begin : g_lim
    assign limit[g] = base[g] + AW'(depth[g] - CW'(1));
  end
endmodule

// File: rtl/fpart_fifo_ptr.sv
module fpart_fifo_ptr #(
  parameter int AW = 12,
  parameter int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] depth,
  input  logic          push,
  input  logic          pop,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr
);
  logic [AW-1:0] wr_off, rd_off;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] off, input logic [CW-1:0] d);
    return (CW'(off) == d - CW'(1)) ? '0 : off + AW'(1);
  endfunction

  assign full    = (count == depth);
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign wr_addr = base + wr_off;
  assign rd_addr = base + rd_off;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_off <= '0;
      rd_off <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_off <= step(wr_off, depth);
      if (do_pop)  rd_off <= step(rd_off, depth);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/shared_fifo_partitioner.sv
module shared_fifo_partitioner
  import fpart_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [REG_W-1:0]         cfg_wdata,
  input  logic                     tx_idle,
  input  logic                     rx_idle,
  input  logic [NFIFO-1:0]         push,
  input  logic [NFIFO-1:0]         pop,
  output logic [NFIFO-1:0]         full,
  output logic [NFIFO-1:0]         empty,
  output logic [NFIFO-1:0][AW-1:0] wr_addr,
  output logic [NFIFO-1:0][AW-1:0] rd_addr,
  output logic [NFIFO-1:0][AW-1:0] base,
  output logic [NFIFO-1:0][AW-1:0] limit,
  output logic [KBW-1:0]           cfg_tx_kb
);
  logic                     accept;
  logic [NFIFO-1:0][CW-1:0] depth;
  logic                     unused_wdata_bits;

  assign unused_wdata_bits = ^{cfg_wdata[REG_W-1:KEY_BIT+1], cfg_wdata[SIZE_LSB-1:0]};

  fpart_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .key     (cfg_wdata[KEY_BIT]),
    .size_in (cfg_wdata[SIZE_LSB +: KBW]),
    .tx_idle (tx_idle),
    .rx_idle (rx_idle),
    .tx_kb   (cfg_tx_kb),
    .accept  (accept)
  );

  fpart_region_map u_map (
    .tx_kb (cfg_tx_kb),
    .base  (base),
    .limit (limit),
    .depth (depth)
  );

  for (genvar g = 0; g < NFIFO; g++) begin : g_fifo
    fpart_fifo_ptr #(.AW(AW), .CW(CW)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (accept),
      .base    (base[g]),
      .depth   (depth[g]),
      .push    (push[g]),
      .pop     (pop[g]),
      .full    (full[g]),
      .empty   (empty[g]),
      .wr_addr (wr_addr[g]),
      .rd_addr (rd_addr[g])
    );
  end
endmodule

// File: rtl/shared_fifo_partitioner_chk.sv
module shared_fifo_partitioner_chk
  import fpart_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we,
  input logic                     cfg_key,
  input logic                     tx_idle,
  input logic                     rx_idle,
  input logic [NFIFO-1:0]         push,
  input logic [NFIFO-1:0]         pop,
  input logic [NFIFO-1:0]         full,
  input logic [NFIFO-1:0]         empty,
  input logic [NFIFO-1:0][AW-1:0] wr_addr,
  input logic [NFIFO-1:0][AW-1:0] rd_addr,
  input logic [NFIFO-1:0][AW-1:0] base,
  input logic [NFIFO-1:0][AW-1:0] limit,
  input logic [KBW-1:0]           cfg_tx_kb
);
  logic acc;
  assign acc = cfg_we && cfg_key && tx_idle && rx_idle;

  // R3
  size_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_tx_kb >= KBW'(MIN_KB)) && (cfg_tx_kb <= KBW'(MAX_KB)));

  // R4
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !(tx_idle && rx_idle)) |=> $stable(cfg_tx_kb));

  // R5
  map_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base[0] == '0) && (limit[NFIFO-1] == AW'(MEM_WORDS - 1)));

  for (genvar g = 0; g < NFIFO; g++) begin : g_q
    if (g < NFIFO - 1) begin : g_adj
      // R5
      region_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base[g+1] == limit[g] + AW'(1));
    end

    // R6
    addr_in_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_addr[g] >= base[g]) && (wr_addr[g] <= limit[g]) &&
      (rd_addr[g] >= base[g]) && (rd_addr[g] <= limit[g]));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full[g] && push[g] && !acc) |=> (wr_addr[g] == $past(wr_addr[g])));

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty[g] && pop[g] && !acc) |=> (rd_addr[g] == $past(rd_addr[g])));

    // R10
    reconfig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (empty[g] && !full[g] && (wr_addr[g] == base[g]) && (rd_addr[g] == base[g])));
  end
endmodule

bind shared_fifo_partitioner shared_fifo_partitioner_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_key   (cfg_wdata[fpart_pkg::KEY_BIT]),
  .tx_idle   (tx_idle),
  .rx_idle   (rx_idle),
  .push      (push),
  .pop       (pop),
  .full      (full),
  .empty     (empty),
  .wr_addr   (wr_addr),
  .rd_addr   (rd_addr),
  .base      (base),
  .limit     (limit),
  .cfg_tx_kb (cfg_tx_kb)
);

// File: tb/sim_shared_fifo_partitioner.sv
`timescale 1ns/1ps
module sim_shared_fifo_partitioner;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [31:0]       cfg_wdata = '0;
  logic              tx_idle = 1'b0;
  logic              rx_idle = 1'b0;
  logic [3:0]        push = '0;
  logic [3:0]        pop = '0;
  logic [3:0]        full, empty;
  logic [3:0][11:0]  wr_addr, rd_addr, base, limit;
  logic [3:0]        cfg_tx_kb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_kb;
  int m_cnt[4];
  int m_wo[4];
  int m_ro[4];

  always #2 clk = ~clk;

  shared_fifo_partitioner u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_idle(tx_idle), .rx_idle(rx_idle), .push(push), .pop(pop),
    .full(full), .empty(empty), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .base(base), .limit(limit), .cfg_tx_kb(cfg_tx_kb)
  );

  function automatic int f_base(int k, int i);
    case (i)
      0: return 0;
      1: return 128;
      2: return k * 256;
      default: return k * 256 + 128;
    endcase
  endfunction

  function automatic int f_depth(int k, int i);
    case (i)
      0: return 128;
      1: return k * 256 - 128;
      2: return 128;
      default: return 4096 - k * 256 - 128;
    endcase
  endfunction

  function automatic int f_clamp(int v);
    if (v < 2) return 2;
    if (v > 14) return 14;
    return v;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "cfg_tx_kb", int'(cfg_tx_kb), m_kb);
    for (int i = 0; i < 4; i++) begin
      chk(req, $sformatf("base[%0d]", i), int'(base[i]), f_base(m_kb, i));
      chk(req, $sformatf("limit[%0d]", i), int'(limit[i]), f_base(m_kb, i) + f_depth(m_kb, i) - 1);
      chk(req, $sformatf("wr_addr[%0d]", i), int'(wr_addr[i]), f_base(m_kb, i) + m_wo[i]);
      chk(req, $sformatf("rd_addr[%0d]", i), int'(rd_addr[i]), f_base(m_kb, i) + m_ro[i]);
      chk(req, $sformatf("full[%0d]", i), int'(full[i]), int'(m_cnt[i] == f_depth(m_kb, i)));
      chk(req, $sformatf("empty[%0d]", i), int'(empty[i]), int'(m_cnt[i] == 0));
    end
  endtask

  function automatic void model_step(logic [3:0] p, logic [3:0] q, logic we,
                                     logic [31:0] wd, logic ti, logic ri);
    if (we && ti && ri && wd[20]) begin
      m_kb = f_clamp(int'(wd[19:16]));
      for (int i = 0; i < 4; i++) begin
        m_cnt[i] = 0; m_wo[i] = 0; m_ro[i] = 0;
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        int d;
        bit dp, dq;
        d  = f_depth(m_kb, i);
        dp = p[i] && (m_cnt[i] != d);
        dq = q[i] && (m_cnt[i] != 0);
        if (dp) m_wo[i] = (m_wo[i] == d - 1) ? 0 : m_wo[i] + 1;
        if (dq) m_ro[i] = (m_ro[i] == d - 1) ? 0 : m_ro[i] + 1;
        m_cnt[i] = m_cnt[i] + int'(dp) - int'(dq);
      end
    end
  endfunction

  task automatic apply(logic [3:0] p, logic [3:0] q, logic we, logic [31:0] wd,
                       logic ti, logic ri, string req);
    push = p; pop = q; cfg_we = we; cfg_wdata = wd; tx_idle = ti; rx_idle = ri;
    model_step(p, q, we, wd, ti, ri);
    @(negedge clk);
    check_all(req);
  endtask

  function automatic logic [31:0] cfg_word(int kb, bit key);
    return (32'(key) << 20) | (32'(kb & 15) << 16);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    m_kb = 5;
    for (int i = 0; i < 4; i++) begin
      m_cnt[i] = 0; m_wo[i] = 0; m_ro[i] = 0;
    end
    repeat (3) @(negedge clk);
    check_all("R1");
    chk("R1", "base[3] literal", int'(base[3]), 1408);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R6 / R7: fill transmit status region to the brim, wrapping the write pointer
    repeat (128) apply(4'b0001, 4'b0000, 0, '0, 1, 1, "R6");
    chk("R7", "full[0] after 128 pushes", int'(full[0]), 1);
    apply(4'b0001, 4'b0000, 0, '0, 1, 1, "R7");
    chk("R7", "wr_addr[0] held at base", int'(wr_addr[0]), 0);
    // R8: drain, then pop once more
    repeat (128) apply(4'b0000, 4'b0001, 0, '0, 1, 1, "R6");
    apply(4'b0000, 4'b0001, 0, '0, 1, 1, "R8");
    chk("R8", "empty[0] held", int'(empty[0]), 1);
    // R9: push and pop together on transmit data
    repeat (3) apply(4'b0010, 4'b0000, 0, '0, 1, 1, "R9");
    repeat (5) apply(4'b0010, 4'b0010, 0, '0, 1, 1, "R9");
    chk("R9", "wr_addr[1]", int'(wr_addr[1]), 128 + 8);
    chk("R9", "rd_addr[1]", int'(rd_addr[1]), 128 + 5);

    // R4: gated writes
    apply(4'b0000, 4'b0000, 1, cfg_word(9, 1), 0, 1, "R4");
    apply(4'b0000, 4'b0000, 1, cfg_word(9, 1), 1, 0, "R4");
    apply(4'b0000, 4'b0000, 1, cfg_word(9, 0), 1, 1, "R4");
    chk("R4", "cfg_tx_kb unchanged", int'(cfg_tx_kb), 5);
    // R3: clamping at both ends
    apply(4'b0000, 4'b0000, 1, cfg_word(0, 1), 1, 1, "R3");
    chk("R3", "low clamp", int'(cfg_tx_kb), 2);
    chk("R5", "rx data depth limit", int'(limit[3]) - int'(base[3]) + 1, 3456);
    apply(4'b0000, 4'b0000, 1, cfg_word(15, 1), 1, 1, "R3");
    chk("R3", "high clamp", int'(cfg_tx_kb), 14);
    // R2: plain accepted write
    apply(4'b0000, 4'b0000, 1, cfg_word(9, 1), 1, 1, "R2");
    chk("R2", "cfg_tx_kb", int'(cfg_tx_kb), 9);
    chk("R5", "rx status base", int'(base[2]), 2304);
    // R10: config collides with traffic
    repeat (4) apply(4'b1111, 4'b0000, 0, '0, 1, 1, "R6");
    apply(4'b1111, 4'b1111, 1, cfg_word(6, 1), 1, 1, "R10");
    chk("R10", "all empty", int'(empty), 15);

    // random traffic with occasional configuration attempts
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] p, q;
      logic we, ti, ri;
      logic [31:0] wd;
      p  = 4'($urandom);
      q  = 4'($urandom) & 4'($urandom);
      we = ($urandom % 150) == 0;
      ti = ($urandom % 3) != 0;
      ri = ($urandom % 3) != 0;
      wd = cfg_word(int'($urandom % 16), ($urandom % 4) != 0);
      apply(p, q, we, wd, ti, ri, "R6 R7 R8 R9 R10");
    end
    push = '0; pop = '0; cfg_we = 0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule